// File: doc/BRIEF.md
# Sensor Capture Instruction Sequencer

This block is a hard-wired instruction source for a programmable communication controller. It replaces a stored program with a small state machine. The sequence it produces has three parts. First comes an instruction that loads the controller's address register. Next comes the start address as an operand word. Last comes a fixed number of autoincrementing block-write instructions, each moving a burst of sensor words into memory. After the final write, the block presents a stall instruction and stays there.

Each cycle the block presents three outputs: an instruction word, a control bit and a valid flag. The control bit is 1 for an instruction and 0 for an operand. The controller pulses a read strobe when it takes the word, and the block then steps forward. During the streaming phase, the valid flag follows the sensor's data-available input, so the controller only sees a write instruction when a burst is actually waiting. The opcodes, burst length, start address and write count are all parameters.

Top module: `seqcap_top`

## Requirements
- R1: A synchronous active-high reset returns the block to its first step and clears the write counter. The next cycle shows the load-address instruction, with control bit 1 and valid 1.
- R2: The load-address word holds OP_LOAD_AREG in its top OPC_W bits, with zeros below. It stays on the outputs until a cycle in which the read strobe is high.
- R3: The operand word holds START_ADDR in its low ADDR_W bits, with zeros above. Its control bit is 0 and valid is 1. It stays until the read strobe is high.
- R4: The write word holds OP_WRITE in its top OPC_W bits and BURST_LEN (default 8) in its low bits. Its control bit is 1. During streaming, valid equals the sensor-valid input in the same cycle.
- R5: A write is consumed only in a cycle where the read strobe and sensor-valid are both high. A read strobe in any other streaming cycle has no effect.
- R6: The cycle after the NUM_WRITES-th (default 1024) write is consumed, the block shows the stall word: OP_STALL in the top bits, zeros below, control bit 0, valid 0. It stays there, whatever the read strobe does, until reset.
- R7: Between resets, the controller consumes exactly one load word, then one operand word, then NUM_WRITES write words, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_rd | input | 1 | Controller read strobe for the presented word |
| sensor_valid | input | 1 | Sensor has a burst of data ready |
| instr_word | output | WORD_W | Instruction or operand word |
| ctrl_bit | output | 1 | 1 = instruction, 0 = operand |
| word_valid | output | 1 | Presented word may be read |

## Verification
The most delicate cycle is the one where the final write is consumed. In that cycle the counter reaches its limit and the state moves to stall, both on the same edge. The bench provokes this by holding the read strobe and sensor-valid high through the end of the run. It then judges the result in two ways: the scoreboard must have consumed exactly the expected count, and the very next cycle must show the stall word with valid low. A second coincidence is a read strobe that arrives while sensor-valid is low. The random patterns produce this often, and any stray count would empty the scoreboard early or misalign it.

// File: rtl/seqcap_pkg.sv
package seqcap_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_OPER  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seqcap_fsm.sv
module seqcap_fsm
  import seqcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       word_rd,
  input  logic       word_valid,
  input  logic       last_write,
  output seq_state_t state
);
  seq_state_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_LOAD:  if (word_rd && !rst) state_nx = ST_OPER;
      ST_OPER:  if (word_rd) state_nx = ST_WRITE;
      ST_WRITE: if (word_rd && word_valid && last_write) state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_DONE;
      default:  state_nx = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_LOAD;
    else     state <= state_nx;
  end

  a_r1_reset_to_load: assert property (@(posedge clk)
    rst |=> state == ST_LOAD);
  a_r2_load_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && !word_rd) |=> state == ST_LOAD);
  a_r3_oper_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPER && !word_rd) |=> state == ST_OPER);
  a_r6_done_terminal: assert property (@(posedge clk) disable iff (rst)
    state == ST_DONE |=> state == ST_DONE);
endmodule

// File: rtl/seqcap_counter.sv
module seqcap_counter #(
  parameter int NUM_WRITES = 1024,
  localparam int CNT_W = $clog2(NUM_WRITES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= count + CNT_W'(1);
  end

  a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + CNT_W'(1)));
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(NUM_WRITES));
endmodule

// File: rtl/seqcap_word.sv
module seqcap_word
  import seqcap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPC_W  = 4,
  parameter int ADDR_W = 24,
  parameter int BURST_LEN = 8,
  parameter logic [OPC_W-1:0]  OP_LOAD_AREG = OPC_W'('h3),
  parameter logic [OPC_W-1:0]  OP_WRITE     = OPC_W'('h9),
  parameter logic [OPC_W-1:0]  OP_STALL     = OPC_W'('hF),
  parameter logic [ADDR_W-1:0] START_ADDR   = ADDR_W'('h01_0000)
) (
  input  seq_state_t        state,
  input  logic              sensor_valid,
  output logic [WORD_W-1:0] instr_word,
  output logic              ctrl_bit,
  output logic              word_valid
);
  localparam int OPD_W = WORD_W - OPC_W;
  localparam logic [WORD_W-1:0] W_LOAD  = {OP_LOAD_AREG, {OPD_W{1'b0}}};
  localparam logic [WORD_W-1:0] W_OPER  = {{(WORD_W-ADDR_W){1'b0}}, START_ADDR};
  localparam logic [WORD_W-1:0] W_WRITE = {OP_WRITE, OPD_W'(BURST_LEN)};
  localparam logic [WORD_W-1:0] W_STALL = {OP_STALL, {OPD_W{1'b0}}};

  always_comb begin
    unique case (state)
      ST_LOAD:  begin instr_word = W_LOAD;  ctrl_bit = 1'b1; word_valid = 1'b1; end
      ST_OPER:  begin instr_word = W_OPER;  ctrl_bit = 1'b0; word_valid = 1'b1; end
      ST_WRITE: begin instr_word = W_WRITE; ctrl_bit = 1'b1; word_valid = sensor_valid; end
      default:  begin instr_word = W_STALL; ctrl_bit = 1'b0; word_valid = 1'b0; end
    endcase
  end
endmodule

// File: rtl/seqcap_top.sv
module seqcap_top
  import seqcap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPC_W  = 4,
  parameter int ADDR_W = 24,
  parameter int BURST_LEN = 8,
  parameter int NUM_WRITES = 1024,
  parameter logic [OPC_W-1:0]  OP_LOAD_AREG = OPC_W'('h3),
  parameter logic [OPC_W-1:0]  OP_WRITE     = OPC_W'('h9),
  parameter logic [OPC_W-1:0]  OP_STALL     = OPC_W'('hF),
  parameter logic [ADDR_W-1:0] START_ADDR   = ADDR_W'('h01_0000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_rd,
  input  logic              sensor_valid,
  output logic [WORD_W-1:0] instr_word,
  output logic              ctrl_bit,
  output logic              word_valid
);
  localparam int CNT_W = $clog2(NUM_WRITES + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] count;
  logic             step;
  logic             last_write;

  assign step       = (state == ST_WRITE) && word_rd && word_valid;
  assign last_write = (count == CNT_W'(NUM_WRITES - 1));

  seqcap_fsm u_fsm (
    .clk(clk), .rst(rst), .word_rd(word_rd), .word_valid(word_valid),
    .last_write(last_write), .state(state)
  );

  seqcap_counter #(.NUM_WRITES(NUM_WRITES)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .count(count)
  );

  seqcap_word #(
    .WORD_W(WORD_W), .OPC_W(OPC_W), .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
    .OP_LOAD_AREG(OP_LOAD_AREG), .OP_WRITE(OP_WRITE), .OP_STALL(OP_STALL),
    .START_ADDR(START_ADDR)
  ) u_word (
    .state(state), .sensor_valid(sensor_valid), .instr_word(instr_word),
    .ctrl_bit(ctrl_bit), .word_valid(word_valid)
  );

  a_r4_valid_follows_sensor: assert property (@(posedge clk) disable iff (rst)
    state == ST_WRITE |-> word_valid == sensor_valid);
  a_r6_done_at_limit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) == (count == CNT_W'(NUM_WRITES)));
  a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
    state == ST_DONE |-> !word_valid && !ctrl_bit);
  a_r5_no_count_outside_write: assert property (@(posedge clk) disable iff (rst)
    state != ST_WRITE |=> count == $past(count));
endmodule

// File: tb/tb_seqcap_top.sv
module tb_seqcap_top;
  localparam int NW = 1024;
  localparam logic [31:0] W_LOAD  = 32'h3000_0000;
  localparam logic [31:0] W_OPER  = 32'h0001_0000;
  localparam logic [31:0] W_WRITE = 32'h9000_0008;
  localparam logic [31:0] W_STALL = 32'hF000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_rd = 1'b0;
  logic sensor_valid = 1'b0;
  logic [31:0] instr_word;
  logic ctrl_bit, word_valid;

  int checks = 0;
  int errors = 0;
  int consumed = 0;
  logic [32:0] exp_q[$];

  always #4 clk = ~clk;

  seqcap_top dut (
    .clk(clk), .rst(rst), .word_rd(word_rd), .sensor_valid(sensor_valid),
    .instr_word(instr_word), .ctrl_bit(ctrl_bit), .word_valid(word_valid)
  );

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_program();
    exp_q.delete();
    consumed = 0;
    exp_q.push_back({1'b1, W_LOAD});
    exp_q.push_back({1'b0, W_OPER});
    for (int i = 0; i < NW; i++) exp_q.push_back({1'b1, W_WRITE});
  endtask

  // Monitor: compares the presented word with the scoreboard front each cycle.
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (exp_q.size() != 0) begin
        logic [32:0] f;
        string req;
        logic exp_v;
        f = exp_q[0];
        req = (f[31:0] == W_LOAD) ? "R2" : (f[31:0] == W_OPER) ? "R3" : "R4";
        exp_v = (f[31:0] == W_WRITE) ? sensor_valid : 1'b1;
        check({ctrl_bit, instr_word} == f, {req, "/R7 word"}, {ctrl_bit, instr_word}, f);
        check(word_valid == exp_v, {req, " valid"}, {32'd0, word_valid}, {32'd0, exp_v});
        if (word_rd && word_valid) begin
          void'(exp_q.pop_front());
          consumed++;
        end
      end else begin
        check({ctrl_bit, instr_word} == {1'b0, W_STALL} && !word_valid, "R6 stall",
              {ctrl_bit, instr_word}, {1'b0, W_STALL});
      end
    end
  end

  task automatic cycle(input logic rd, input logic sv);
    @(negedge clk);
    word_rd = rd;
    sensor_valid = sv;
  endtask

  initial begin
    int wd;
    push_program();
    repeat (3) cycle(1'b0, 1'b0);
    rst = 1'b0;
    // partial run, then reset in mid-stream
    for (int i = 0; i < 200; i++) cycle(1'($urandom % 2), 1'($urandom % 2));
    @(negedge clk);
    word_rd = 1'b1; sensor_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    #2;
    check({ctrl_bit, instr_word} == {1'b1, W_LOAD} && word_valid, "R1 reset word",
          {ctrl_bit, instr_word}, {1'b1, W_LOAD});
    push_program();
    word_rd = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R2: no read for several cycles, load word must hold
    repeat (3) cycle(1'b0, 1'b1);
    #2;
    check(instr_word == W_LOAD, "R2 hold", {1'b0, instr_word}, {1'b0, W_LOAD});
    // random stream; strobes while sensor low must be ignored (R5)
    wd = 0;
    while (exp_q.size() > 40 && wd < 100000) begin
      cycle(1'($urandom % 2), 1'($urandom % 3 != 0));
      wd++;
    end
    // tail: both high so last write and stall transition coincide
    while (exp_q.size() != 0 && wd < 100000) begin
      cycle(1'b1, 1'b1);
      wd++;
    end
    if (wd >= 100000) check(1'b0, "watchdog", 33'd0, 33'd1);
    repeat (20) cycle(1'b1, 1'b1);
    check(consumed == NW + 2, "R5/R7 consumed count", 33'(consumed), 33'(NW + 2));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule